// File: doc/BRIEF.md
# Log-Structured Page-Mapped Flash Translator

This block turns host reads and writes on logical page numbers into commands for a raw flash array. The array is modelled inside the block. A write is never done in place. Each write is appended to the next free page of the block that is currently filling, and a per-logical-page table is pointed at that physical page. A read looks the logical page up in the table and fetches the physical page it names. Flash cannot be programmed until its whole block has been erased, so the controller erases a fresh block before the first program into it. It fills each block from its lowest page upward.

The host sees a valid/ready request channel. A request carries a write flag, a logical page number and write data. Each request is answered by a one-cycle done pulse that carries read data and two status flags: unmapped (a read of a page that was never written) and full (a write refused because no erased page and no unused block remain). The controller handles one request at a time. It keeps its ready low while the request is in flight, which includes the fixed busy time of each flash operation. When the controller programs a page it stores the logical page number next to the data as out-of-band metadata. A read cross-checks that tag against the logical page it asked for. Reclaiming stale pages is outside this block, so once every physical page has been programmed, further writes are refused.

Top module: `lpm_xlat`

## Requirements
- R1: After reset, req_ready is 1, rsp_done is 0, and no logical page is mapped.
- R2: A read of a logical page that has never been written ends with rsp_unmapped = 1, rsp_full = 0 and rsp_rdata = 0 during the done pulse.
- R3: After a write of data D to logical page L (req_lpn is 4 bits, so L is 0 to 15), a read of L returns D with rsp_unmapped = 0.
- R4: Overwriting logical page L sends the new data to a fresh physical page and redirects the table, so a later read of L returns the newest data and other logical pages keep their data. The page fetched for L carries L as its out-of-band tag.
- R5: A page is programmed only after its block has been erased. A write that has to open a new block takes at least BUSY_CYC cycles longer than a write into an already erased page. All writes into already erased pages take the same number of cycles.
- R6: Blocks are opened in ascending order and pages within a block are programmed in ascending order, so exactly PAGES_PER_BLK*NUM_BLKS (12 by default) writes succeed, whatever their logical pages.
- R7: A write issued when no erased page and no unused block remain finishes with a done pulse and rsp_full = 1. It changes no mapping: a logical page it named reads back as unmapped and earlier data stays readable.
- R8: From the cycle a request is accepted until its done pulse, req_ready stays 0, and no flash operation is outstanding while req_ready is 1.
- R9: rsp_done is high for exactly one cycle per request, and the response fields are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lpn | input | LPN_W (4) | Logical page number |
| req_wdata | input | DATA_W (16) | Data to write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W (16) | Read data, zero for writes and unmapped reads |
| rsp_unmapped | output | 1 | Read targeted a page with no mapping |
| rsp_full | output | 1 | Write refused, no free flash left |

## Verification
The bench targets the writes that open a block. A controller that programs without erasing first would lose data, and one that erases on every write would make every write slow. Both show up as wrong read-back values or as uneven write latencies. Overwrites are read back next to untouched neighbours, because a table update aimed at the wrong entry would corrupt a neighbour or leave a stale value visible. The capacity edge is tested with writes spread across several logical pages. A skipped or reused page changes the count of successful writes, and a refused write that still updated the table makes its page readable instead of unmapped.

// File: rtl/pf_pkg.sv
package pf_pkg;
   // condition of one physical page as seen by the controller
   typedef enum logic [1:0] {
      PG_INVALID = 2'd0,
      PG_ERASED  = 2'd1,
      PG_VALID   = 2'd2
   } pg_state_e;

   // operations the raw array accepts
   typedef enum logic [1:0] {
      FC_READ  = 2'd0,
      FC_PROG  = 2'd1,
      FC_ERASE = 2'd2
   } fcmd_e;

   // controller sequencing
   typedef enum logic [3:0] {
      S_IDLE,
      S_DECIDE,
      S_ERASE,
      S_ERASE_WAIT,
      S_PROG,
      S_PROG_WAIT,
      S_READ,
      S_READ_WAIT,
      S_RESP
   } xl_state_e;
endpackage

// File: rtl/pf_flash_model.sv
module pf_flash_model
   import pf_pkg::*;
#(
   parameter int DATA_W        = 16,
   parameter int LPN_W         = 4,
   parameter int PAGES_PER_BLK = 4,
   parameter int NUM_BLKS      = 3,
   parameter int BUSY_CYC      = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cmd_vld,
   input  fcmd_e                        cmd,
   input  logic [PPN_W-1:0]             addr,
   input  logic [DATA_W-1:0]            wdata,
   input  logic [LPN_W-1:0]             woob,
   output logic                         busy,
   output logic                         done,
   output logic [DATA_W-1:0]            rdata,
   output logic [LPN_W-1:0]             roob
);
   localparam int NUM_PAGES = PAGES_PER_BLK * NUM_BLKS;
   localparam int PG_W      = $clog2(PAGES_PER_BLK);
   localparam int BLK_W     = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1;
   localparam int PPN_W     = BLK_W + PG_W;
   localparam int CNT_W     = $clog2(BUSY_CYC + 1);

   logic [DATA_W-1:0] mem    [NUM_PAGES];
   logic [LPN_W-1:0]  oob    [NUM_PAGES];
   logic              erased [NUM_PAGES];

   logic [CNT_W-1:0]  cnt;
   fcmd_e             op;
   logic [PPN_W-1:0]  op_addr;
   logic [DATA_W-1:0] op_data;
   logic [LPN_W-1:0]  op_oob;

   assign busy = (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         done    <= 1'b0;
         rdata   <= '0;
         roob    <= '0;
         op      <= FC_READ;
         op_addr <= '0;
         op_data <= '0;
         op_oob  <= '0;
         for (int i = 0; i < NUM_PAGES; i++) begin
            mem[i]    <= '0;
            oob[i]    <= '0;
            erased[i] <= 1'b0;
         end
      end else begin
         done <= 1'b0;
         if (cmd_vld && !busy) begin
            op      <= cmd;
            op_addr <= addr;
            op_data <= wdata;
            op_oob  <= woob;
            cnt     <= CNT_W'(BUSY_CYC);
         end else if (busy) begin
            cnt <= cnt - CNT_W'(1);
            if (cnt == CNT_W'(1)) begin
               done <= 1'b1;
               case (op)
                  FC_ERASE: begin
                     for (int i = 0; i < NUM_PAGES; i++) begin
                        if ((i / PAGES_PER_BLK) == int'(op_addr[PPN_W-1:PG_W])) begin
                           mem[i]    <= '1;
                           erased[i] <= 1'b1;
                        end
                     end
                  end
                  FC_PROG: begin
                     // raw flash ignores a program onto a page that is not erased
                     if (erased[op_addr]) begin
                        mem[op_addr]    <= op_data;
                        oob[op_addr]    <= op_oob;
                        erased[op_addr] <= 1'b0;
                     end
                  end
                  default: begin
                     rdata <= mem[op_addr];
                     roob  <= oob[op_addr];
                  end
               endcase
            end
         end
      end
   end

   AST_PROG_ON_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && cmd == FC_PROG) |-> erased[addr]) else $error("program on unerased page"); // R5

   AST_NO_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_vld |-> !busy) else $error("command issued while array busy"); // R8
endmodule

// File: rtl/pf_map_table.sv
module pf_map_table #(
   parameter int LPN_W = 4,
   parameter int PPN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LPN_W-1:0] lk_lpn,
   output logic             lk_present,
   output logic [PPN_W-1:0] lk_ppn,
   input  logic             upd_en,
   input  logic [LPN_W-1:0] upd_lpn,
   input  logic [PPN_W-1:0] upd_ppn
);
   localparam int LPN_CNT = 1 << LPN_W;

   logic             present [LPN_CNT];
   logic [PPN_W-1:0] ppn_tab [LPN_CNT];

   assign lk_present = present[lk_lpn];
   assign lk_ppn     = ppn_tab[lk_lpn];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < LPN_CNT; i++) begin
            present[i] <= 1'b0;
            ppn_tab[i] <= '0;
         end
      end else if (upd_en) begin
         present[upd_lpn] <= 1'b1;
         ppn_tab[upd_lpn] <= upd_ppn;
      end
   end

   AST_MAP_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && lk_lpn == upd_lpn) |=> (lk_present && lk_ppn == $past(upd_ppn))) else $error("mapping not redirected"); // R4
endmodule

// File: rtl/pf_alloc.sv
module pf_alloc
   import pf_pkg::*;
#(
   parameter int PAGES_PER_BLK = 4,
   parameter int NUM_BLKS      = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             erase_go,
   input  logic             prog_go,
   output logic [PPN_W-1:0] wr_ppn,
   output logic [BLK_W-1:0] erase_blk,
   output logic             need_erase,
   output logic             full
);
   localparam int NUM_PAGES = PAGES_PER_BLK * NUM_BLKS;
   localparam int PG_W      = $clog2(PAGES_PER_BLK);
   localparam int BLK_W     = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1;
   localparam int PPN_W     = BLK_W + PG_W;
   localparam int NBLK_W    = $clog2(NUM_BLKS + 1);

   logic              have_act;
   logic [BLK_W-1:0]  act_blk;
   logic [PG_W-1:0]   act_pg;
   logic [NBLK_W-1:0] next_blk;
   pg_state_e         pst [NUM_PAGES];

   assign wr_ppn     = {act_blk, act_pg};
   assign erase_blk  = next_blk[BLK_W-1:0];
   assign need_erase = !have_act;
   assign full       = !have_act && (next_blk == NBLK_W'(NUM_BLKS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_act <= 1'b0;
         act_blk  <= '0;
         act_pg   <= '0;
         next_blk <= '0;
      end else if (erase_go) begin
         have_act <= 1'b1;
         act_blk  <= erase_blk;
         act_pg   <= '0;
         next_blk <= next_blk + NBLK_W'(1);
      end else if (prog_go) begin
         act_pg <= act_pg + PG_W'(1);
         if (act_pg == PG_W'(PAGES_PER_BLK - 1)) have_act <= 1'b0;
      end
   end

   // one state register per physical page
   for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
      localparam logic [BLK_W-1:0] P_BLK = BLK_W'(p / PAGES_PER_BLK);
      localparam logic [PPN_W-1:0] P_PPN = PPN_W'((p / PAGES_PER_BLK) * (1 << PG_W) + (p % PAGES_PER_BLK));
      pg_state_e st_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              st_q <= PG_INVALID;
         else if (erase_go && erase_blk == P_BLK) st_q <= PG_ERASED;
         else if (prog_go && wr_ppn == P_PPN)     st_q <= PG_VALID;
      end
      assign pst[p] = st_q;
   end

   logic [PPN_W-1:0] wr_idx;
   logic [PPN_W-1:0] prev_idx;
   assign wr_idx   = PPN_W'(int'(act_blk) * PAGES_PER_BLK + int'(act_pg));
   assign prev_idx = wr_idx - PPN_W'(1);

   AST_PROG_TARGET_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
      prog_go |-> (have_act && pst[wr_idx] == PG_ERASED)) else $error("target page not erased"); // R5

   AST_PROG_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_go && act_pg != '0) |-> pst[prev_idx] == PG_VALID) else $error("page order skipped"); // R6

   AST_ERASE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      erase_go |-> (need_erase && !full)) else $error("erase without need"); // R6
endmodule

// File: rtl/lpm_xlat.sv
module lpm_xlat
   import pf_pkg::*;
#(
   parameter int DATA_W        = 16,
   parameter int LPN_W         = 4,
   parameter int PAGES_PER_BLK = 4,
   parameter int NUM_BLKS      = 3,
   parameter int BUSY_CYC      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [LPN_W-1:0]  req_lpn,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_unmapped,
   output logic              rsp_full
);
   localparam int PG_W  = $clog2(PAGES_PER_BLK);
   localparam int BLK_W = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1;
   localparam int PPN_W = BLK_W + PG_W;

   // elaboration-time parameter checks
   if (PAGES_PER_BLK < 2 || (PAGES_PER_BLK & (PAGES_PER_BLK - 1)) != 0) begin : g_bad_ppb
      $error("PAGES_PER_BLK must be a power of two of at least 2");
   end
   if (NUM_BLKS < 1) begin : g_bad_blks
      $error("NUM_BLKS must be at least 1");
   end
   if (BUSY_CYC < 1) begin : g_bad_busy
      $error("BUSY_CYC must be at least 1");
   end
   if (DATA_W < 1 || LPN_W < 1) begin : g_bad_w
      $error("widths must be positive");
   end

   xl_state_e         state;
   logic              c_write;
   logic [LPN_W-1:0]  c_lpn;
   logic [DATA_W-1:0] c_wdata;
   logic [DATA_W-1:0] rdata_q;
   logic              unm_q;
   logic              full_q;

   // flash side
   logic              fl_cmd_vld;
   fcmd_e             fl_cmd;
   logic [PPN_W-1:0]  fl_addr;
   logic              fl_busy;
   logic              fl_done;
   logic [DATA_W-1:0] fl_rdata;
   logic [LPN_W-1:0]  fl_roob;

   // allocator and table
   logic [PPN_W-1:0]  wr_ppn;
   logic [BLK_W-1:0]  erase_blk;
   logic              need_erase;
   logic              no_space;
   logic              lk_present;
   logic [PPN_W-1:0]  lk_ppn;
   logic              erase_go;
   logic              prog_go;

   assign req_ready    = (state == S_IDLE);
   assign rsp_done     = (state == S_RESP);
   assign rsp_rdata    = rdata_q;
   assign rsp_unmapped = unm_q;
   assign rsp_full     = full_q;

   assign erase_go = (state == S_ERASE);
   assign prog_go  = (state == S_PROG);

   always_comb begin
      fl_cmd_vld = 1'b0;
      fl_cmd     = FC_READ;
      fl_addr    = lk_ppn;
      case (state)
         S_ERASE: begin
            fl_cmd_vld = 1'b1;
            fl_cmd     = FC_ERASE;
            fl_addr    = {erase_blk, {PG_W{1'b0}}};
         end
         S_PROG: begin
            fl_cmd_vld = 1'b1;
            fl_cmd     = FC_PROG;
            fl_addr    = wr_ppn;
         end
         S_READ: begin
            fl_cmd_vld = 1'b1;
            fl_cmd     = FC_READ;
            fl_addr    = lk_ppn;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         c_write <= 1'b0;
         c_lpn   <= '0;
         c_wdata <= '0;
         rdata_q <= '0;
         unm_q   <= 1'b0;
         full_q  <= 1'b0;
      end else begin
         case (state)
            S_IDLE: if (req_valid) begin
               c_write <= req_write;
               c_lpn   <= req_lpn;
               c_wdata <= req_wdata;
               rdata_q <= '0;
               unm_q   <= 1'b0;
               full_q  <= 1'b0;
               state   <= S_DECIDE;
            end
            S_DECIDE: begin
               if (c_write) begin
                  if (no_space) begin
                     full_q <= 1'b1;
                     state  <= S_RESP;
                  end else if (need_erase) begin
                     state <= S_ERASE;
                  end else begin
                     state <= S_PROG;
                  end
               end else if (!lk_present) begin
                  unm_q <= 1'b1;
                  state <= S_RESP;
               end else begin
                  state <= S_READ;
               end
            end
            S_ERASE:      state <= S_ERASE_WAIT;
            S_ERASE_WAIT: if (fl_done) state <= S_PROG;
            S_PROG:       state <= S_PROG_WAIT;
            S_PROG_WAIT:  if (fl_done) state <= S_RESP;
            S_READ:       state <= S_READ_WAIT;
            S_READ_WAIT: if (fl_done) begin
               rdata_q <= fl_rdata;
               state   <= S_RESP;
            end
            S_RESP:  state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   pf_flash_model #(
      .DATA_W(DATA_W), .LPN_W(LPN_W), .PAGES_PER_BLK(PAGES_PER_BLK),
      .NUM_BLKS(NUM_BLKS), .BUSY_CYC(BUSY_CYC)
   ) u_flash (
      .clk(clk), .rst_n(rst_n), .cmd_vld(fl_cmd_vld), .cmd(fl_cmd),
      .addr(fl_addr), .wdata(c_wdata), .woob(c_lpn),
      .busy(fl_busy), .done(fl_done), .rdata(fl_rdata), .roob(fl_roob)
   );

   pf_alloc #(
      .PAGES_PER_BLK(PAGES_PER_BLK), .NUM_BLKS(NUM_BLKS)
   ) u_alloc (
      .clk(clk), .rst_n(rst_n), .erase_go(erase_go), .prog_go(prog_go),
      .wr_ppn(wr_ppn), .erase_blk(erase_blk), .need_erase(need_erase), .full(no_space)
   );

   pf_map_table #(
      .LPN_W(LPN_W), .PPN_W(PPN_W)
   ) u_map (
      .clk(clk), .rst_n(rst_n), .lk_lpn(c_lpn), .lk_present(lk_present), .lk_ppn(lk_ppn),
      .upd_en(prog_go), .upd_lpn(c_lpn), .upd_ppn(wr_ppn)
   );

   AST_OOB_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_READ_WAIT && fl_done) |-> fl_roob == c_lpn) else $error("stale page read"); // R4

   AST_HOLD_WHILE_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
      fl_busy |-> !req_ready) else $error("ready while flash busy"); // R8

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done) else $error("done longer than one cycle"); // R9

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && rsp_unmapped) |-> (rsp_rdata == '0 && !rsp_full)) else $error("unmapped read not zero"); // R2

   AST_FULL_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && rsp_full) |-> c_write) else $error("full flag on a read"); // R7
endmodule

// File: tb/lpm_xlat_test.sv
module lpm_xlat_test;
   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 16;
   localparam int LPN_W      = 4;
   localparam int BUSY_CYC   = 3;
   localparam int CAPACITY   = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic              req_write = 1'b0;
   logic [LPN_W-1:0]  req_lpn = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic              rsp_done;
   logic [DATA_W-1:0] rsp_rdata;
   logic              rsp_unmapped;
   logic              rsp_full;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int lat_open;
   int lat_a;
   int lat_b;

   always #(CLK_PERIOD / 2) clk = ~clk;

   lpm_xlat #(.DATA_W(DATA_W), .LPN_W(LPN_W), .PAGES_PER_BLK(4), .NUM_BLKS(3), .BUSY_CYC(BUSY_CYC)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_lpn(req_lpn), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_unmapped(rsp_unmapped), .rsp_full(rsp_full)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         errors = errors + 1;
         $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // issue one request, return its response and cycles from accept to done
   task automatic do_op(input logic wr, input logic [LPN_W-1:0] lpn, input logic [DATA_W-1:0] d,
                        output logic [DATA_W-1:0] rd, output logic unm, output logic full, output int lat);
      logic ready_seen;
      ready_seen = 1'b0;
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_lpn   = lpn;
      req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!rsp_done && lat < 1000) begin
         if (req_ready) ready_seen = 1'b1;
         @(negedge clk);
         lat = lat + 1;
      end
      rd   = rsp_rdata;
      unm  = rsp_unmapped;
      full = rsp_full;
      check("R8 ready low while busy", {31'd0, ready_seen}, 32'd0);
      @(negedge clk);
      check("R9 done single cycle", {31'd0, rsp_done}, 32'd0);
   endtask

   task automatic wr_ok(input logic [LPN_W-1:0] lpn, input logic [DATA_W-1:0] d, output int lat);
      logic [DATA_W-1:0] rd;
      logic unm, full;
      do_op(1'b1, lpn, d, rd, unm, full, lat);
      check("R6 write within capacity not full", {31'd0, full}, 32'd0);
   endtask

   task automatic rd_exp(input string req, input logic [LPN_W-1:0] lpn, input logic [DATA_W-1:0] exp);
      logic [DATA_W-1:0] rd;
      logic unm, full;
      int lat;
      do_op(1'b0, lpn, '0, rd, unm, full, lat);
      check(req, {16'd0, rd}, {16'd0, exp});
      check(req, {31'd0, unm}, 32'd0);
   endtask

   task automatic rd_unmapped(input string req, input logic [LPN_W-1:0] lpn);
      logic [DATA_W-1:0] rd;
      logic unm, full;
      int lat;
      do_op(1'b0, lpn, '0, rd, unm, full, lat);
      check(req, {31'd0, unm}, 32'd1);
      check(req, {16'd0, rd}, 32'd0);
      check(req, {31'd0, full}, 32'd0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 ready after reset", {31'd0, req_ready}, 32'd1);
      check("R1 done low after reset", {31'd0, rsp_done}, 32'd0);
      rd_unmapped("R1 nothing mapped lpn 0", 4'd0);
   endtask

   task automatic t_unmapped();
      rd_unmapped("R2 unmapped read lpn 7", 4'd7);
      rd_unmapped("R2 unmapped read lpn 15", 4'd15);
   endtask

   task automatic t_write_read();
      wr_ok(4'd5, 16'hA5A1, lat_open);
      wr_ok(4'd9, 16'h1234, lat_a);
      wr_ok(4'd15, 16'hBEEF, lat_b);
      rd_exp("R3 read back lpn 5", 4'd5, 16'hA5A1);
      rd_exp("R3 read back lpn 9", 4'd9, 16'h1234);
      rd_exp("R3 read back lpn 15", 4'd15, 16'hBEEF);
      check("R5 erased-page writes equal latency", lat_a, lat_b);
      check("R5 block-opening write slower", {31'd0, (lat_open >= lat_a + BUSY_CYC)}, 32'd1);
   endtask

   task automatic t_overwrite();
      int lat;
      wr_ok(4'd5, 16'hC0DE, lat);
      check("R5 last page of block no erase", lat, lat_a);
      rd_exp("R4 overwrite visible", 4'd5, 16'hC0DE);
      rd_exp("R4 neighbour lpn 9 intact", 4'd9, 16'h1234);
      wr_ok(4'd5, 16'hD00D, lat);
      check("R5 second block opened with erase", {31'd0, (lat >= lat_a + BUSY_CYC)}, 32'd1);
      rd_exp("R4 overwrite into new block", 4'd5, 16'hD00D);
      rd_exp("R4 neighbour lpn 15 intact", 4'd15, 16'hBEEF);
   endtask

   task automatic t_fill();
      logic [DATA_W-1:0] rd;
      logic unm, full;
      int lat;
      int idx;
      logic [LPN_W-1:0] fl_lpns [7] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd10};
      // five pages used so far, seven more reach CAPACITY
      for (int i = 0; i < 7; i++) begin
         wr_ok(fl_lpns[i], 16'h7000 + 16'(i), lat);
      end
      do_op(1'b1, 4'd8, 16'hFFFF, rd, unm, full, lat);
      check("R7 write past capacity refused", {31'd0, full}, 32'd1);
      do_op(1'b1, 4'd5, 16'h0BAD, rd, unm, full, lat);
      check("R7 repeated refusal", {31'd0, full}, 32'd1);
      rd_unmapped("R7 refused write left lpn 8 unmapped", 4'd8);
      rd_exp("R7 refused overwrite kept lpn 5", 4'd5, 16'hD00D);
      idx = 0;
      for (int i = 0; i < 7; i++) begin
         rd_exp("R6 filled page reads back", fl_lpns[i], 16'h7000 + 16'(i));
         idx = idx + 1;
      end
      check("R6 all fill pages checked", idx, 7);
      rd_exp("R3 early data survives fill", 4'd9, 16'h1234);
      rd_unmapped("R2 lpn 7 still unmapped at end", 4'd7);
      check("R6 capacity constant", CAPACITY, 12);
   endtask

   initial begin
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_unmapped();
      t_write_read();
      t_overwrite();
      t_fill();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule